// File: doc/BRIEF.md
# Vector Floating-Point Sign Operation Unit

This unit changes only the sign bits of IEEE floating-point values packed into a 128-bit vector. Three sign operations are offered: flip the sign, make it negative, or make it positive. Every other bit of each element passes through unchanged. A request carries the source vector, the current destination vector, an element-format code, two modifier fields and a strap that enables the wider set of formats.

In all-elements mode the operation applies to every 32-bit or 64-bit element. In single-element mode only the most significant element changes. In that mode the lower doubleword of the result keeps the prior destination contents. The 128-bit format always counts as one element: its upper doubleword takes the sign operation and its lower doubleword is copied from the source. A request with an illegal combination of fields returns a specification-exception flag in place of data. The result and the flag come back registered, one cycle after the request.

Top module: `vfp_sign_unit`

## Requirements
- R1: The operation code sets what happens to each selected sign bit: 0 inverts it, 1 sets it to one, 2 clears it to zero. No other bit of a selected element changes.
- R2: An operation code greater than 2 raises the specification exception.
- R3: Any nonzero bit among bits 2..0 of the 4-bit control field raises the specification exception.
- R4: With control bit 3 clear, format code 2 (32-bit) applies the operation at bits 127, 95, 63 and 31. Format code 3 (64-bit) applies it at bits 127 and 63.
- R5: With the enhancement strap low, only format code 3 is legal. Any other format code raises the specification exception.
- R6: Format codes other than 2, 3 and 4 raise the specification exception.
- R7: Format code 4 (128-bit) is always single-element, whatever control bit 3 holds. Bits 127..64 are the source with the operation applied at bit 127, and bits 63..0 are a copy of the source.
- R8: With control bit 3 set and format code 2 or 3, bits 127..64 are the source with the operation applied at bit 127 only, and bits 63..0 are the destination input's bits 63..0.
- R9: The output valid is high exactly one cycle after each cycle with input valid high, and low otherwise. Back-to-back requests are each answered in turn.
- R10: When the exception flag is returned, the result vector is all zeros. After reset, the output valid, the flag and the result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request qualifier |
| src_vec | input | 128 | Source vector (element 0 at bit 127) |
| dst_vec | input | 128 | Current destination vector |
| fmt | input | 4 | Element format code: 2 = 32-bit, 3 = 64-bit, 4 = 128-bit |
| ctl | input | 4 | Control field: bit 3 selects single-element mode, bits 2..0 must be zero |
| sop | input | 4 | Sign operation code |
| enh_en | input | 1 | Strap that enables the 32-bit and 128-bit formats |
| out_valid | output | 1 | Result qualifier, one cycle after in_valid |
| out_vec | output | 128 | Result vector, zero when the exception is flagged |
| out_spec_exc | output | 1 | Specification-exception flag |

## Verification
Every result, whether data or exception, is due one clock after the request. The bench drives each request on a falling edge and samples the outputs on the next falling edge, after the one rising edge that registers them. It then holds the valid low for one cycle and checks that the output valid has dropped. The sweep covers every format code, control field, operation code and strap value against several data patterns. Back-to-back requests check that each result appears in its own cycle.

// File: rtl/vfp_sign_pkg.sv
package vfp_sign_pkg;
  localparam int VEC_W     = 128;
  localparam int LANE_W    = 32;
  localparam int DW_W      = 64;
  localparam int NUM_LANES = VEC_W / LANE_W;
  localparam int LOW_LANES = DW_W / LANE_W;
  localparam int LPD       = DW_W / LANE_W;

  localparam logic [3:0] FMT_SHORT = 4'd2;
  localparam logic [3:0] FMT_LONG  = 4'd3;
  localparam logic [3:0] FMT_EXT   = 4'd4;

  typedef enum logic [1:0] {
    SOP_FLIP = 2'd0,
    SOP_NEG  = 2'd1,
    SOP_POS  = 2'd2,
    SOP_RSVD = 2'd3
  } sign_op_e;

  function automatic logic apply_sign(input logic b, input sign_op_e op);
    case (op)
      SOP_FLIP: return ~b;
      SOP_NEG:  return 1'b1;
      SOP_POS:  return 1'b0;
      default:  return b;
    endcase
  endfunction

  // One bit per 32-bit lane: set when that lane's top bit is a sign bit to change.
  function automatic logic [NUM_LANES-1:0] lane_select(input logic [3:0] fmt,
                                                       input logic single);
    logic [NUM_LANES-1:0] s;
    s = '0;
    if (fmt == FMT_EXT || single) begin
      s[NUM_LANES-1] = 1'b1;
    end else if (fmt == FMT_SHORT) begin
      s = '1;
    end else if (fmt == FMT_LONG) begin
      for (int k = 0; k < NUM_LANES; k++)
        if ((k % LPD) == LPD - 1) s[k] = 1'b1;
    end
    return s;
  endfunction
endpackage

// File: rtl/vfp_sign_decode.sv
module vfp_sign_decode
  import vfp_sign_pkg::*;
(
  input  logic [3:0]           fmt,
  input  logic [3:0]           ctl,
  input  logic [3:0]           sop,
  input  logic                 enh_en,
  output logic                 spec_exc,
  output sign_op_e             op,
  output logic [NUM_LANES-1:0] lane_sel,
  output logic [NUM_LANES-1:0] lane_keep_dst
);
  logic bad_sop, bad_ctl, bad_fmt, no_enh, single;

  assign bad_sop  = (sop > 4'd2);
  assign bad_ctl  = (ctl[2:0] != 3'b000);
  assign bad_fmt  = !(fmt == FMT_SHORT || fmt == FMT_LONG || fmt == FMT_EXT);
  assign no_enh   = !enh_en && (fmt != FMT_LONG);
  assign spec_exc = bad_sop | bad_ctl | bad_fmt | no_enh;
  assign single   = ctl[3];
  assign op       = sign_op_e'(sop[1:0]);
  assign lane_sel = lane_select(fmt, single);

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_keep
    if (k < LOW_LANES) begin : g_low
      assign lane_keep_dst[k] = single && (fmt != FMT_EXT);
    end else begin : g_high
      assign lane_keep_dst[k] = 1'b0;
    end
  end

  // R4: a legal request touches one, two or four sign bits
  always_comb begin
    if (!spec_exc)
      a_r4_lane_count: assert ($countones(lane_sel) == 1 || $countones(lane_sel) == 2 ||
                               $countones(lane_sel) == NUM_LANES);
  end
  // R8: lanes kept from the destination never also take a sign change
  always_comb begin
    a_r8_keep_disjoint: assert ((lane_keep_dst & lane_sel) == '0);
  end
endmodule

// File: rtl/vfp_sign_lanes.sv
module vfp_sign_lanes
  import vfp_sign_pkg::*;
(
  input  logic [VEC_W-1:0]     src,
  input  logic [VEC_W-1:0]     dst,
  input  sign_op_e             op,
  input  logic [NUM_LANES-1:0] lane_sel,
  input  logic [NUM_LANES-1:0] lane_keep_dst,
  output logic [VEC_W-1:0]     res
);
  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    logic [LANE_W-1:0] l_src, l_dst, l_mod;
    assign l_src = src[k*LANE_W +: LANE_W];
    assign l_dst = dst[k*LANE_W +: LANE_W];
    assign l_mod = {lane_sel[k] ? apply_sign(l_src[LANE_W-1], op) : l_src[LANE_W-1],
                    l_src[LANE_W-2:0]};
    assign res[k*LANE_W +: LANE_W] = lane_keep_dst[k] ? l_dst : l_mod;
  end
endmodule

// File: rtl/vfp_sign_unit.sv
module vfp_sign_unit
  import vfp_sign_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [127:0] src_vec,
  input  logic [127:0] dst_vec,
  input  logic [3:0]   fmt,
  input  logic [3:0]   ctl,
  input  logic [3:0]   sop,
  input  logic         enh_en,
  output logic         out_valid,
  output logic [127:0] out_vec,
  output logic         out_spec_exc
);
  logic                 spec_exc;
  sign_op_e             op;
  logic [NUM_LANES-1:0] lane_sel, lane_keep_dst;
  logic [VEC_W-1:0]     res;

  vfp_sign_decode u_dec (
    .fmt(fmt), .ctl(ctl), .sop(sop), .enh_en(enh_en),
    .spec_exc(spec_exc), .op(op), .lane_sel(lane_sel), .lane_keep_dst(lane_keep_dst)
  );

  vfp_sign_lanes u_lanes (
    .src(src_vec), .dst(dst_vec), .op(op),
    .lane_sel(lane_sel), .lane_keep_dst(lane_keep_dst), .res(res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_spec_exc <= 1'b0;
      out_vec      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_spec_exc <= spec_exc;
        out_vec      <= spec_exc ? '0 : res;
      end
    end
  end

  // R9: exactly one cycle of latency
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2: reserved operation codes
  a_r2_bad_sop: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sop > 4'd2) |=> out_spec_exc);
  // R3: low control bits must be zero
  a_r3_bad_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ctl[2:0] != 3'b000) |=> out_spec_exc);
  // R10: no data alongside an exception
  a_r10_exc_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_spec_exc) |-> (out_vec == '0));
  // R7: extended format copies the low doubleword from the source
  a_r7_ext_low: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !spec_exc && fmt == FMT_EXT) |=> (out_vec[63:0] == $past(src_vec[63:0])));
  // R8: single-element mode keeps the destination's low doubleword
  a_r8_single_low: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !spec_exc && ctl[3] && fmt != FMT_EXT) |=>
    (out_vec[63:0] == $past(dst_vec[63:0])));
  // R1: flipping on the 64-bit format, all elements
  a_r1_flip_long: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enh_en && fmt == FMT_LONG && ctl == 4'd0 && sop == 4'd0) |=>
    (out_vec == ($past(src_vec) ^ {1'b1, 63'd0, 1'b1, 63'd0})));
endmodule

// File: tb/sim_vfp_sign_unit.sv
`timescale 1ns/1ps
module sim_vfp_sign_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] src_vec = '0, dst_vec = '0;
  logic [3:0]   fmt = '0, ctl = '0, sop = '0;
  logic         enh_en = 1'b0;
  logic         out_valid, out_spec_exc;
  logic [127:0] out_vec;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vfp_sign_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec), .dst_vec(dst_vec),
    .fmt(fmt), .ctl(ctl), .sop(sop), .enh_en(enh_en),
    .out_valid(out_valid), .out_vec(out_vec), .out_spec_exc(out_spec_exc)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic new_sign(input logic b, input logic [3:0] s);
    if (s == 4'd0) return !b;
    return (s == 4'd1);
  endfunction

  function automatic logic model_exc(input logic [3:0] f, input logic [3:0] c,
                                     input logic [3:0] s, input logic e, output string why);
    why = "";
    if (s >= 4'd3) why = "R2";
    else if (c[2:0] != 0) why = "R3";
    else if (f != 2 && f != 3 && f != 4) why = "R6";
    else if (!e && f != 3) why = "R5";
    return (why != "");
  endfunction

  function automatic logic [127:0] model_vec(input logic [127:0] s_v, input logic [127:0] d_v,
                                             input logic [3:0] f, input logic [3:0] c,
                                             input logic [3:0] s);
    logic [127:0] r;
    if (f == 4 || c[3]) begin
      r = {s_v[127:64], (f == 4) ? s_v[63:0] : d_v[63:0]};
      r[127] = new_sign(s_v[127], s);
    end else begin
      int w;
      w = (f == 2) ? 32 : 64;
      r = s_v;
      for (int p = w - 1; p < 128; p += w) r[p] = new_sign(s_v[p], s);
    end
    return r;
  endfunction

  task automatic run_one(input logic [127:0] s_v, input logic [127:0] d_v,
                         input logic [3:0] f, input logic [3:0] c, input logic [3:0] s,
                         input logic e);
    string why, tag;
    logic ex;
    src_vec = s_v; dst_vec = d_v; fmt = f; ctl = c; sop = s; enh_en = e; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    ex = model_exc(f, c, s, e, why);
    check("R9 valid", {127'd0, out_valid}, 128'd1);
    check(ex ? why : "R2/R3/R5/R6 legal", {127'd0, out_spec_exc}, {127'd0, ex});
    if (ex) tag = "R10 zero data";
    else if (f == 4) tag = "R1/R7 extended";
    else if (c[3]) tag = "R1/R8 single";
    else tag = "R1/R4 all";
    check(tag, out_vec, ex ? 128'd0 : model_vec(s_v, d_v, f, c, s));
    @(negedge clk);
    check("R9 idle", {127'd0, out_valid}, 128'd0);
  endtask

  initial begin
    logic [127:0] pats [4];
    pats[0] = '0;
    pats[1] = '1;
    pats[2] = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
    pats[3] = 128'h8000_0001_7fff_fffe_c3a5_5a3c_0f0f_f0f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R10 reset valid", {127'd0, out_valid}, 128'd0);
    check("R10 reset exc", {127'd0, out_spec_exc}, 128'd0);
    check("R10 reset data", out_vec, 128'd0);

    for (int p = 0; p < 4; p++)
      for (int f = 0; f < 16; f++)
        for (int c = 0; c < 16; c++)
          for (int s = 0; s < 16; s++)
            for (int e = 0; e < 2; e++)
              run_one(pats[p], ~pats[(p + 1) % 4] ^ 128'h5, 4'(f), 4'(c), 4'(s), e[0]);

    // R9: back-to-back requests
    src_vec = pats[2]; dst_vec = pats[3]; fmt = 4'd2; ctl = 4'd0; sop = 4'd1; enh_en = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    check("R9 b2b first", out_vec, model_vec(pats[2], pats[3], 4'd2, 4'd0, 4'd1));
    src_vec = pats[3]; fmt = 4'd4; sop = 4'd2;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 b2b second valid", {127'd0, out_valid}, 128'd1);
    check("R9 b2b second", out_vec, model_vec(pats[3], pats[3], 4'd4, 4'd0, 4'd2));
    @(negedge clk);
    check("R9 b2b idle", {127'd0, out_valid}, 128'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule